// File: doc/BRIEF.md
# Sixteen-Channel Charge Sum Processor

This block sits on a front-end digitizer board and turns one beat of sixteen 10-bit photomultiplier samples per 100 MHz clock into a compact summary for the next trigger stage. Each channel is scaled by its own gain coefficient. A slow recursive average tracks the channel's baseline, and that average is subtracted from the scaled sample. From the corrected samples the block forms the total charge, the index of the brightest channel and the earliest arrival time among channels above threshold. It packs these into one 48-bit result word per beat. The raw beats are also copied into a small FIFO for later readout.

Samples enter on a valid/ready stream and results leave on another. The datapath is a four-register pipeline that moves as one unit. When the consumer holds `out_ready` low while a result is waiting, the whole pipeline freezes, `in_ready` drops, and the result word stays unchanged until it is taken. A producer may only change `in_samples` once its beat has been accepted (`in_valid` and `in_ready` both high at a clock edge). The configuration inputs (gains, shift, threshold, mode) are sampled while beats move through the pipeline. They must be held steady while beats are in flight.

Top module: `charge_sum_proc`

## Requirements
- R1: Each channel's gained sample is floor(raw × gain / 64), where the channel's gain is an 8-bit unsigned value with 6 fractional bits taken from `gain_coef[8i+7:8i]` and the raw sample from `in_samples[10i+9:10i]`.
- R2: The corrected sample is the gained sample minus the integer part of the channel baseline. A negative result is clamped to 0. A channel counts as hit when its corrected sample is strictly greater than `hit_thresh`.
- R3: The baseline is held with 8 fractional bits and starts at 0 after reset. On a beat where the channel is not hit, it moves by (gained×256 − baseline) arithmetically shifted right by `base_shift`. On a hit beat it stays unchanged.
- R4: `out_word[23:0]` is the sum of the sixteen corrected samples of the beat.
- R5: `out_word[27:24]` is the index of the channel with the largest corrected sample. When several channels share the maximum, the lowest index is reported, so all-zero beats report 0.
- R6: Accepted beats are numbered from 0 after reset, modulo 4096. A channel's arrival time is the number of the beat on which it last went from not hit to hit. `out_word[39:28]` is the smallest arrival time among channels hit on this beat, or 12'hFFF when none is hit.
- R7: With `secondary_mode` high, `out_word[39:24]` is zero and only the charge sum and hit flag are reported.
- R8: Results come out one per accepted beat, in order. With `out_ready` high, a beat accepted at clock edge A shows `out_valid` high after edge A+3.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_word` hold their values at the next edge.
- R10: Every accepted beat is written to the raw FIFO (depth 16) unless the FIFO is full, in which case the beat is dropped. `fifo_data` shows the oldest entry, and `fifo_rd` removes it.
- R11: After reset, `out_valid` is low, `in_ready` is high, `fifo_empty` is high and `fifo_full` is low.
- R12: `out_word[40]` is high when any channel is hit on the beat, and `out_word[47:41]` is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample beat is offered |
| in_ready | output | 1 | Pipeline can accept a beat |
| in_samples | input | 160 | Sixteen 10-bit raw samples, channel i at bits 10i+9:10i |
| gain_coef | input | 128 | Sixteen 8-bit gains (6 fractional bits), channel i at bits 8i+7:8i |
| base_shift | input | 4 | Baseline tracker shift, sets its corner frequency |
| hit_thresh | input | 12 | Hit threshold on corrected samples |
| secondary_mode | input | 1 | Report charge sum only |
| out_valid | output | 1 | Result word is valid |
| out_ready | input | 1 | Consumer accepts the result word |
| out_word | output | 48 | Packed result |
| fifo_rd | input | 1 | Remove the oldest raw beat |
| fifo_data | output | 160 | Oldest raw beat in the FIFO |
| fifo_empty | output | 1 | FIFO holds no beat |
| fifo_full | output | 1 | FIFO holds 16 beats |

## Verification
The bench first lets the baselines settle with the threshold set out of reach, then sends pulses so that some channels are hit while others keep tracking. A design that updated the baseline during a hit would pull the pedestal up into the pulse and shrink later sums. A design that used floor division of a negative step incorrectly would drift by one count. Ties between equal pulses and all-zero beats target the lowest-index rule, where a non-strict comparison would report the higher channel. Repeated crossings target the arrival-time logic, which could otherwise latch the time of every hit beat instead of the rising edge. Random back-pressure stalls the pipeline mid-burst and the FIFO is overfilled: a design that let the result word change during a stall, or that overwrote the FIFO head when full, would show up as a mismatched word or a wrong raw beat on readout.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int CH_N      = 16;
  localparam int SMP_W     = 10;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 6;
  localparam int BASE_FRAC = 8;
  localparam int SHIFT_W   = 4;
  localparam int TIME_W    = 12;
  localparam int SUM_W     = 24;
  localparam int WORD_W    = 48;
  localparam int FIFO_DEPTH = 16;
  localparam int CORR_W    = SMP_W + GAIN_W - GAIN_FRAC;
  localparam int IDX_W     = $clog2(CH_N);
  localparam int HIT_BIT   = SUM_W + IDX_W + TIME_W;
endpackage

// File: rtl/csp_chan.sv
module csp_chan #(
  parameter int SMP_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int BASE_FRAC = 8,
  parameter int SHIFT_W   = 4,
  parameter int TIME_W    = 12,
  localparam int CORR_W   = SMP_W + GAIN_W - GAIN_FRAC,
  localparam int BQ_W     = CORR_W + BASE_FRAC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               v2,
  input  logic [SMP_W-1:0]   raw,
  input  logic [GAIN_W-1:0]  gain,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CORR_W-1:0]  thr,
  input  logic [TIME_W-1:0]  ts2,
  output logic [CORR_W-1:0]  corr,
  output logic               hit,
  output logic [TIME_W-1:0]  t_arr
);
  logic [SMP_W+GAIN_W-1:0] prod;
  logic [CORR_W-1:0]       g_q;
  logic [BQ_W-1:0]         base_q;
  logic [BQ_W-1:0]         base_nx;
  logic                    hit_prev;
  logic [TIME_W-1:0]       first_t;
  logic signed [CORR_W:0]  diff_i;
  logic signed [BQ_W:0]    delta;
  logic signed [BQ_W:0]    step;
  logic [CORR_W-1:0]       c_n;
  logic                    hit_n;
  logic [TIME_W-1:0]       t_n;

  assign prod = raw * gain;

  // stage 2: gain equalisation
  always_ff @(posedge clk) begin
    if (!rst_n)  g_q <= '0;
    else if (en) g_q <= CORR_W'(prod >> GAIN_FRAC);
  end

  // stage 3: baseline subtraction, hit detection, tracker update
  always_comb begin
    diff_i  = $signed({1'b0, g_q}) - $signed({1'b0, base_q[BQ_W-1:BASE_FRAC]});
    c_n     = diff_i[CORR_W] ? '0 : diff_i[CORR_W-1:0];
    hit_n   = c_n > thr;
    delta   = $signed({1'b0, g_q, {BASE_FRAC{1'b0}}}) - $signed({1'b0, base_q});
    step    = delta >>> shift;
    base_nx = BQ_W'($signed({1'b0, base_q}) + step);
    t_n     = (hit_n && !hit_prev) ? ts2 : first_t;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      hit_prev <= 1'b0;
      first_t  <= '0;
      corr     <= '0;
      hit      <= 1'b0;
      t_arr    <= '0;
    end else if (en) begin
      corr  <= c_n;
      hit   <= v2 && hit_n;
      t_arr <= t_n;
      if (v2) begin
        hit_prev <= hit_n;
        first_t  <= t_n;
        if (!hit_n) base_q <= base_nx;
      end
    end
  end

  // R3: tracker frozen while the channel is hit
  p_base_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v2 && hit_n) |=> $stable(base_q));
endmodule

// File: rtl/csp_reduce.sv
module csp_reduce #(
  parameter int CH_N   = 16,
  parameter int CORR_W = 12,
  parameter int TIME_W = 12,
  parameter int SUM_W  = 24,
  parameter int WORD_W = 48,
  localparam int IDX_W = $clog2(CH_N),
  localparam int HIT_BIT = SUM_W + IDX_W + TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CORR_W-1:0] corr [CH_N],
  input  logic [CH_N-1:0]   hit_vec,
  input  logic [TIME_W-1:0] t_arr [CH_N],
  input  logic              secondary_mode,
  output logic [WORD_W-1:0] word_q
);
  logic [SUM_W-1:0]  sum;
  logic [CORR_W-1:0] mx;
  logic [IDX_W-1:0]  idx;
  logic [TIME_W-1:0] tmin;
  logic [WORD_W-1:0] word_n;

  always_comb begin
    sum  = '0;
    mx   = '0;
    idx  = '0;
    tmin = '1;
    for (int i = 0; i < CH_N; i++) begin
      sum = sum + SUM_W'(corr[i]);
      if (corr[i] > mx) begin   // strict: lowest index keeps a tie
        mx  = corr[i];
        idx = IDX_W'(i);
      end
      if (hit_vec[i] && (t_arr[i] < tmin)) tmin = t_arr[i];
    end
    word_n = '0;
    word_n[SUM_W-1:0] = sum;
    if (!secondary_mode) begin
      word_n[SUM_W +: IDX_W]          = idx;
      word_n[SUM_W + IDX_W +: TIME_W] = tmin;
    end
    word_n[HIT_BIT] = |hit_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  word_q <= '0;
    else if (en) word_q <= word_n;
  end

  // R7: secondary mode leaves index and time fields clear
  p_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && secondary_mode) |=> (word_q[SUM_W +: IDX_W + TIME_W] == '0));
endmodule

// File: rtl/csp_fifo.sv
module csp_fifo #(
  parameter int W     = 160,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10: a write into a full FIFO is dropped
  p_drop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/charge_sum_proc.sv
module charge_sum_proc
  import csp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [CH_N*SMP_W-1:0]     in_samples,
  input  logic [CH_N*GAIN_W-1:0]    gain_coef,
  input  logic [SHIFT_W-1:0]        base_shift,
  input  logic [CORR_W-1:0]         hit_thresh,
  input  logic                      secondary_mode,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORD_W-1:0]         out_word,
  input  logic                      fifo_rd,
  output logic [CH_N*SMP_W-1:0]     fifo_data,
  output logic                      fifo_empty,
  output logic                      fifo_full
);
  logic                    en, accept;
  logic                    v1, v2, v3, v4;
  logic [CH_N*SMP_W-1:0]   raw1;
  logic [TIME_W-1:0]       ts_cnt, ts1, ts2;
  logic [CORR_W-1:0]       corr_a [CH_N];
  logic [TIME_W-1:0]       t_a    [CH_N];
  logic [CH_N-1:0]         hit_v;

  assign en        = !v4 || out_ready;
  assign in_ready  = en;
  assign accept    = in_valid && en;
  assign out_valid = v4;

  // stage 1 and pipeline bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, v2, v3, v4} <= '0;
      raw1   <= '0;
      ts_cnt <= '0;
      ts1    <= '0;
      ts2    <= '0;
    end else begin
      if (accept) ts_cnt <= ts_cnt + 1'b1;
      if (en) begin
        v1   <= in_valid;
        v2   <= v1;
        v3   <= v2;
        v4   <= v3;
        raw1 <= in_samples;
        ts1  <= ts_cnt;
        ts2  <= ts1;
      end
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    csp_chan #(
      .SMP_W(SMP_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
      .BASE_FRAC(BASE_FRAC), .SHIFT_W(SHIFT_W), .TIME_W(TIME_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_n), .en(en), .v2(v2),
      .raw(raw1[i*SMP_W +: SMP_W]),
      .gain(gain_coef[i*GAIN_W +: GAIN_W]),
      .shift(base_shift), .thr(hit_thresh), .ts2(ts2),
      .corr(corr_a[i]), .hit(hit_v[i]), .t_arr(t_a[i])
    );
  end

  csp_reduce #(
    .CH_N(CH_N), .CORR_W(CORR_W), .TIME_W(TIME_W),
    .SUM_W(SUM_W), .WORD_W(WORD_W)
  ) u_reduce (
    .clk(clk), .rst_n(rst_n), .en(en),
    .corr(corr_a), .hit_vec(hit_v), .t_arr(t_a),
    .secondary_mode(secondary_mode), .word_q(out_word)
  );

  csp_fifo #(.W(CH_N*SMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .din(in_samples),
    .pop(fifo_rd), .dout(fifo_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  // R9: a stalled result holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R12: spare bits stay clear
  p_spare_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[WORD_W-1:HIT_BIT+1] == '0));
endmodule

// File: tb/charge_sum_proc_bench.sv
module charge_sum_proc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [159:0] in_samples = '0;
  logic [127:0] gain_coef = '0;
  logic [3:0]   base_shift = '0;
  logic [11:0]  hit_thresh = '0;
  logic secondary_mode = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [47:0] out_word;
  logic fifo_rd = 1'b0;
  logic [159:0] fifo_data;
  logic fifo_empty, fifo_full;

  always #5 clk = ~clk;

  charge_sum_proc u_charge_sum_proc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .gain_coef(gain_coef), .base_shift(base_shift),
    .hit_thresh(hit_thresh), .secondary_mode(secondary_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .fifo_rd(fifo_rd), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  int checks = 0, errors = 0;
  logic [47:0]  exp_q[$];
  logic [159:0] fifo_model[$];
  int base[16], ft[16], gain[16];
  bit hprev[16];
  int ts = 0, kshift = 0, thr = 0;
  bit mode = 0, bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int k, input int t, input bit m);
    kshift = k; thr = t; mode = m;
    base_shift = 4'(k); hit_thresh = 12'(t); secondary_mode = m;
    for (int i = 0; i < 16; i++) gain_coef[i*8 +: 8] = 8'(gain[i]);
  endtask

  // reference model of one accepted beat (R1..R7, R12)
  task automatic model_push(input logic [159:0] raw);
    int sum, mx, idx, tmin;
    bit any;
    logic [47:0] w;
    sum = 0; mx = 0; idx = 0; tmin = 4095; any = 0;
    for (int i = 0; i < 16; i++) begin
      int x, g, c;
      bit h;
      x = int'(raw[i*10 +: 10]);
      g = (x * gain[i]) >> 6;
      c = g - (base[i] >> 8);
      if (c < 0) c = 0;
      h = (c > thr);
      if (!h) base[i] = base[i] + (((g << 8) - base[i]) >>> kshift);
      if (h && !hprev[i]) ft[i] = ts;
      hprev[i] = h;
      sum += c;
      if (c > mx) begin mx = c; idx = i; end
      if (h) begin any = 1; if (ft[i] < tmin) tmin = ft[i]; end
    end
    w = '0;
    w[23:0] = 24'(sum);
    if (!mode) begin w[27:24] = 4'(idx); w[39:28] = 12'(tmin); end
    w[40] = any;
    exp_q.push_back(w);
    ts = (ts + 1) % 4096;
    if (fifo_model.size() < 16) fifo_model.push_back(raw);
  endtask

  task automatic send(input logic [159:0] raw);
    @(negedge clk);
    in_samples = raw;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model_push(raw);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [159:0] mk_raw(input int n, input int ped, input int pmask, input int amp);
    logic [159:0] r;
    for (int i = 0; i < 16; i++) begin
      int v;
      v = ped + 3 * i + ((n + i) % 3);
      if (pmask[i]) v += amp + 7 * (i % 4);
      if (v > 1023) v = 1023;
      r[i*10 +: 10] = 10'(v);
    end
    return r;
  endfunction

  // consumer back-pressure
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor / scoreboard
  bit stalled = 0;
  logic [47:0] stall_word;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (stalled) begin
        chk(out_valid == 1'b1 && out_word == stall_word, "R9 stalled word held",
            {111'b0, out_valid, out_word}, {111'b0, 1'b1, stall_word});
      end
      stalled = out_valid && !out_ready;
      stall_word = out_word;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", {112'b0, out_word}, '0);
        end else begin
          logic [47:0] e;
          e = exp_q.pop_front();
          chk(out_word == e, "R1 R2 R3 R4 R5 R6 R7 R12 result word",
              {112'b0, out_word}, {112'b0, e});
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      base[i] = 0; ft[i] = 0; hprev[i] = 0; gain[i] = 64;
    end
    set_cfg(2, 4095, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid", {159'b0, out_valid}, '0);
    chk(in_ready == 1'b1, "R11 in_ready", {159'b0, in_ready}, 160'd1);
    chk(fifo_empty == 1'b1, "R11 fifo_empty", {159'b0, fifo_empty}, 160'd1);
    chk(fifo_full == 1'b0, "R11 fifo_full", {159'b0, fifo_full}, '0);

    // R8 latency: single beat, count negedges after the accepting edge
    @(negedge clk);
    in_samples = mk_raw(0, 50, 0, 0);
    in_valid = 1'b1;
    #1;
    model_push(in_samples);
    @(posedge clk);
    #1 in_valid = 1'b0;
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      #1;
      chk(out_valid == (n == 4), "R8 latency", {159'b0, out_valid}, {159'b0, (n == 4)});
    end
    drain();

    // R1 R3 baseline settling with unequal gains, no hits
    for (int i = 0; i < 16; i++) gain[i] = 48 + 4 * i;
    set_cfg(2, 4095, 0);
    for (int n = 0; n < 40; n++) send(mk_raw(n, 40, 0, 0));
    drain();

    // R10 FIFO overfilled: first 16 beats kept in order
    chk(fifo_full == 1'b1, "R10 fifo_full", {159'b0, fifo_full}, 160'd1);
    while (fifo_model.size() != 0) begin
      logic [159:0] e;
      @(negedge clk);
      #1;
      e = fifo_model.pop_front();
      chk(fifo_data == e, "R10 fifo order", fifo_data, e);
      fifo_rd = 1'b1;
      @(posedge clk);
      #1 fifo_rd = 1'b0;
    end
    @(negedge clk);
    #1;
    chk(fifo_empty == 1'b1, "R10 fifo drained", {159'b0, fifo_empty}, 160'd1);

    // R2 R3 R6 pulses with hits while other channels track
    set_cfg(3, 20, 0);
    for (int n = 0; n < 30; n++)
      send(mk_raw(n, 40, ((n % 5) < 2) ? 16'h0208 : ((n % 7 == 3) ? 16'h8001 : 0), 150 + 10 * n));
    drain();

    // R5 ties: k=0 snaps baselines to equal values, then equal pulses
    for (int i = 0; i < 16; i++) gain[i] = 64;
    set_cfg(0, 4095, 0);
    for (int n = 0; n < 3; n++) send({16{10'd100}});
    drain();
    set_cfg(0, 20, 0);
    send({16{10'd100}});                       // all zero: index 0
    begin
      logic [159:0] r;
      r = {16{10'd100}};
      r[6*10 +: 10]  = 10'd300;
      r[12*10 +: 10] = 10'd300;
      send(r);                                 // tie between 6 and 12
      r[2*10 +: 10]  = 10'd250;
      send(r);                                 // channel 2 crosses later
    end
    drain();

    // R7 secondary mode
    set_cfg(2, 20, 1);
    for (int n = 0; n < 12; n++) send(mk_raw(n, 100, (n % 2) ? 16'h0410 : 0, 200));
    drain();

    // R9 random back-pressure during a burst
    set_cfg(1, 25, 0);
    bp_on = 1;
    for (int n = 0; n < 80; n++) send(mk_raw(n, 90, (n % 4 == 1) ? 16'h1122 : 0, 300 - n));
    bp_on = 0;
    drain();

    chk(exp_q.size() == 0, "R8 all results delivered", 160'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule